// File: doc/BRIEF.md
# Immediate-Operand Integer ALU Unit

This unit executes 32-bit integer instructions whose second operand is a 32-bit immediate carried in the instruction bytes. It takes the instruction one byte at a time from a valid/ready byte stream: an opcode byte, a ModRM byte when the opcode needs one, then four immediate bytes. It reads the destination operand from an external register file or from a memory word, applies the operation, writes the result back, and updates the sign, zero and overflow flags.

Two encodings are decoded. The grouped opcode 0x81 takes its operation from the ModRM sub-field and its destination from the ModRM mode and r/m fields. The short forms always target register 0 (the accumulator) and carry no ModRM byte. A compare updates only the flags. The register file read port is combinational. Memory uses separate read and write strobes that are held until the memory answers with a one-cycle valid.

Top module: `imm_alu_unit`

## Requirements
- R1: After reset the unit is idle: byte_ready_o is 1, done_o and err_o are 0, all three flags are 0, and no register or memory strobe is active.
- R2: The four immediate bytes are assembled least significant byte first, so the bytes 0a 0b 0c 0d form 0x0d0c0b0a. Example: 1 plus that immediate stores 0x0d0c0b0b.
- R3: Under opcode 0x81, ModRM bits [5:3] select the operation: 0 add, 1 or, 4 and, 5 subtract (destination minus immediate), 6 xor, 7 compare.
- R4: ModRM mode bits [7:6] = 11 select register ModRM[2:0] as the destination. The result is written back to that register.
- R5: Mode 00 selects the memory word whose byte address is held in register ModRM[2:0]. That word is read, and for any operation other than compare the result is written back to the same address. The address register itself is left unchanged.
- R6: The short forms operate on register 0 with no ModRM byte: 0x2d subtract, 0x25 and, 0x0d or, 0x35 xor, 0x3d compare.
- R7: Compare computes destination minus immediate and writes nothing back. SF is bit 31 of the difference, ZF is set when the difference is zero, and OF is set on signed overflow of the subtraction.
- R8: Add and subtract set SF from bit 31 of the result and ZF when the result is zero. They set OF when the signed result does not fit in 32 bits.
- R9: Or, and and xor set SF and ZF from the result and clear OF.
- R10: The following encodings raise a one-cycle err_o instead of executing: sub-field 2 or 3 under 0x81, mode 01 or 10, and mode 00 with r/m 100 or 101. For these the immediate is consumed first. An opcode that is neither 0x81 nor a short form raises err_o in the cycle after the opcode byte. In every error case nothing is written and the flags keep their values.
- R11: done_o is high for exactly one cycle, in the cycle after the write-back (or the flag update for compare) completes. byte_ready_o stays low from the last immediate byte until after done_o or err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_valid_i | input | 1 | Instruction byte present |
| byte_i | input | 8 | Instruction byte |
| byte_ready_o | output | 1 | Unit accepts a byte this cycle |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data, same cycle |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| mem_rd_o | output | 1 | Memory read strobe, held until mem_valid_i |
| mem_wr_o | output | 1 | Memory write strobe, held until mem_valid_i |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_valid_i |
| mem_valid_i | input | 1 | Memory completes the pending access |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| of_o | output | 1 | Overflow flag |
| done_o | output | 1 | Instruction completed (one cycle) |
| err_o | output | 1 | Encoding rejected (one cycle) |

## Verification
The assertions assume that mem_valid_i rises only while a read or write strobe is pending and lasts one cycle. They also assume that rf_rdata_i reflects the register selected in the same cycle, and that no other agent changes that register while an instruction is in flight. The bench's register file and memory models are driven only by the unit's own strobes plus preloads made while the unit is idle. Their valid response is registered and cleared after one cycle, so the stimulus never breaks these assumptions.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

  localparam logic [7:0] OPC_GROUP = 8'h81;
  localparam logic [7:0] OPC_SUB_A = 8'h2d;
  localparam logic [7:0] OPC_AND_A = 8'h25;
  localparam logic [7:0] OPC_OR_A  = 8'h0d;
  localparam logic [7:0] OPC_XOR_A = 8'h35;
  localparam logic [7:0] OPC_CMP_A = 8'h3d;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_OR  = 3'd1,
    ALU_AND = 3'd4,
    ALU_SUB = 3'd5,
    ALU_XOR = 3'd6,
    ALU_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic sf;
    logic zf;
    logic of;
  } flags_t;

  function automatic logic is_short(input logic [7:0] b);
    return (b == OPC_SUB_A) || (b == OPC_AND_A) || (b == OPC_OR_A) ||
           (b == OPC_XOR_A) || (b == OPC_CMP_A);
  endfunction

endpackage

// File: rtl/imm_alu_decode.sv
module imm_alu_decode
  import imm_alu_pkg::*;
#(
  parameter int RIDX_W = 3
) (
  input  logic [7:0]        opc_i,
  input  logic [7:0]        modrm_i,
  output alu_op_e           op_o,
  output logic [RIDX_W-1:0] reg_o,
  output logic              mem_o,
  output logic              bad_o
);

  logic [1:0] mode;
  logic [2:0] sub;
  logic [2:0] rm;

  assign mode = modrm_i[7:6];
  assign sub  = modrm_i[5:3];
  assign rm   = modrm_i[2:0];

  always_comb begin
    op_o  = ALU_ADD;
    reg_o = '0;
    mem_o = 1'b0;
    bad_o = 1'b0;
    if (opc_i == OPC_GROUP) begin
      reg_o = RIDX_W'(rm);
      case (sub)
        3'd0: op_o = ALU_ADD;
        3'd1: op_o = ALU_OR;
        3'd4: op_o = ALU_AND;
        3'd5: op_o = ALU_SUB;
        3'd6: op_o = ALU_XOR;
        3'd7: op_o = ALU_CMP;
        default: bad_o = 1'b1;
      endcase
      case (mode)
        2'b11: mem_o = 1'b0;
        2'b00: begin
          mem_o = 1'b1;
          // r/m 100 and 101 need SIB/displacement bytes
          if (rm == 3'd4 || rm == 3'd5) bad_o = 1'b1;
        end
        default: bad_o = 1'b1;
      endcase
    end else begin
      case (opc_i)
        OPC_SUB_A: op_o = ALU_SUB;
        OPC_AND_A: op_o = ALU_AND;
        OPC_OR_A:  op_o = ALU_OR;
        OPC_XOR_A: op_o = ALU_XOR;
        OPC_CMP_A: op_o = ALU_CMP;
        default:   bad_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o,
  output logic              wb_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic              sum_ovf;
  logic              diff_ovf;

  assign sum      = a_i + b_i;
  assign diff     = a_i - b_i;
  assign sum_ovf  = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
  assign diff_ovf = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);

  always_comb begin
    wb_o     = 1'b1;
    flg_o.of = 1'b0;
    case (op_i)
      ALU_ADD: begin res_o = sum;  flg_o.of = sum_ovf;  end
      ALU_SUB: begin res_o = diff; flg_o.of = diff_ovf; end
      ALU_CMP: begin res_o = diff; flg_o.of = diff_ovf; wb_o = 1'b0; end
      ALU_OR:  res_o = a_i | b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_XOR: res_o = a_i ^ b_i;
      default: begin res_o = '0; wb_o = 1'b0; end
    endcase
    flg_o.sf = res_o[MSB];
    flg_o.zf = (res_o == '0);
  end

endmodule

// File: rtl/imm_alu_unit.sv
module imm_alu_unit
  import imm_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              byte_ready_o,
  output logic [2:0]        rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [2:0]        rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_valid_i,
  output logic              sf_o,
  output logic              zf_o,
  output logic              of_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int NB     = DATA_W / 8;
  localparam int CNT_W  = (NB > 1) ? $clog2(NB) : 1;
  localparam int RIDX_W = 3;

  typedef enum logic [2:0] {
    ST_OPC, ST_MODRM, ST_IMM, ST_EXEC, ST_MRD, ST_MWR, ST_DONE, ST_ERR
  } state_e;

  state_e            state_q;
  logic [7:0]        opc_q;
  logic [7:0]        modrm_q;
  logic [DATA_W-1:0] imm_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] res_q;
  logic [CNT_W-1:0]  cnt_q;
  flags_t            flg_q;

  alu_op_e           dec_op;
  logic [RIDX_W-1:0] dec_reg;
  logic              dec_mem;
  logic              dec_bad;
  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_res;
  flags_t            alu_flg;
  logic              alu_wb;
  logic              accept;

  imm_alu_decode #(.RIDX_W(RIDX_W)) u_dec (
    .opc_i  (opc_q),
    .modrm_i(modrm_q),
    .op_o   (dec_op),
    .reg_o  (dec_reg),
    .mem_o  (dec_mem),
    .bad_o  (dec_bad)
  );

  assign alu_a = (state_q == ST_MRD) ? mem_rdata_i : rf_rdata_i;

  imm_alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i (dec_op),
    .a_i  (alu_a),
    .b_i  (imm_q),
    .res_o(alu_res),
    .flg_o(alu_flg),
    .wb_o (alu_wb)
  );

  assign byte_ready_o = (state_q == ST_OPC) || (state_q == ST_MODRM) || (state_q == ST_IMM);
  assign accept       = byte_valid_i && byte_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      opc_q   <= '0;
      modrm_q <= '0;
      imm_q   <= '0;
      addr_q  <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
      flg_q   <= '0;
    end else begin
      case (state_q)
        ST_OPC: if (accept) begin
          opc_q   <= byte_i;
          modrm_q <= '0;
          cnt_q   <= '0;
          if (byte_i == OPC_GROUP)   state_q <= ST_MODRM;
          else if (is_short(byte_i)) state_q <= ST_IMM;
          else                       state_q <= ST_ERR;
        end
        ST_MODRM: if (accept) begin
          modrm_q <= byte_i;
          state_q <= ST_IMM;
        end
        ST_IMM: if (accept) begin
          // shift in from the top: first byte lands in the low lane
          imm_q <= {byte_i, imm_q[DATA_W-1:8]};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(NB - 1)) state_q <= dec_bad ? ST_ERR : ST_EXEC;
        end
        ST_EXEC: begin
          if (dec_mem) begin
            addr_q  <= rf_rdata_i;
            state_q <= ST_MRD;
          end else begin
            flg_q   <= alu_flg;
            state_q <= ST_DONE;
          end
        end
        ST_MRD: if (mem_valid_i) begin
          flg_q   <= alu_flg;
          res_q   <= alu_res;
          state_q <= alu_wb ? ST_MWR : ST_DONE;
        end
        ST_MWR: if (mem_valid_i) state_q <= ST_DONE;
        default: state_q <= ST_OPC;
      endcase
    end
  end

  assign rf_raddr_o  = dec_reg;
  assign rf_waddr_o  = dec_reg;
  assign rf_wdata_o  = alu_res;
  assign rf_we_o     = (state_q == ST_EXEC) && !dec_mem && alu_wb;
  assign mem_rd_o    = (state_q == ST_MRD);
  assign mem_wr_o    = (state_q == ST_MWR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = res_q;
  assign sf_o        = flg_q.sf;
  assign zf_o        = flg_q.zf;
  assign of_o        = flg_q.of;
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_ERR);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o || mem_rd_o || mem_wr_o || done_o || err_o) |-> !byte_ready_o); // R11
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R10
  AST_ERR_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable({sf_o, zf_o, of_o})); // R10
  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, mem_rd_o, mem_wr_o})); // R5
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_valid_i) |=> (mem_rd_o && $stable(mem_addr_o))); // R5
  AST_WR_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_o) |-> $stable(mem_addr_o)); // R5

endmodule

// File: tb/imm_alu_unit_tb.sv
module imm_alu_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        byte_ready;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_rd, mem_wr, mem_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        sf, zf, of_f, done, err;

  logic [31:0] rf [8];
  logic [31:0] mem [16];
  logic        tb_rf_we = 1'b0, tb_mem_we = 1'b0;
  logic [2:0]  tb_rf_idx = '0;
  logic [3:0]  tb_mem_idx = '0;
  logic [31:0] tb_rf_val = '0, tb_mem_val = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit got_done, got_err, ready_busy, done_after;
  bit m_sf = 0, m_zf = 0, m_of = 0;

  always #10 clk = ~clk;

  imm_alu_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .byte_ready_o(byte_ready),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_valid_i(mem_valid),
    .sf_o(sf), .zf_o(zf), .of_o(of_f), .done_o(done), .err_o(err)
  );

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[5:2]];

  always @(posedge clk) begin
    if (tb_rf_we) rf[tb_rf_idx] <= tb_rf_val;
    else if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (tb_mem_we) mem[tb_mem_idx] <= tb_mem_val;
    else if (mem_wr && mem_valid) mem[mem_addr[5:2]] <= mem_wdata;
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mem_valid <= 1'b0;
    else mem_valid <= (mem_rd || mem_wr) && !mem_valid;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input int ridx, input logic [31:0] rval, input bit do_mem,
                         input int midx, input logic [31:0] mval);
    @(negedge clk);
    tb_rf_we = 1; tb_rf_idx = 3'(ridx); tb_rf_val = rval;
    tb_mem_we = do_mem; tb_mem_idx = 4'(midx); tb_mem_val = mval;
    @(negedge clk);
    tb_rf_we = 0; tb_mem_we = 0;
  endtask

  // sends n bytes, then waits for done or err
  task automatic run_instr(input logic [7:0] pkt [6], input int n);
    int w;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid = 1; byte_d = pkt[i];
      while (!byte_ready) @(negedge clk);
    end
    @(negedge clk);
    byte_valid = 0;
    ready_busy = !byte_ready;
    w = 0;
    while (!(done || err) && w < 50) begin @(negedge clk); w++; end
    got_done = done; got_err = err;
    @(negedge clk);
    done_after = done;
  endtask

  function automatic void model(input int sub, input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] r, output bit s, output bit z, output bit o);
    longint sa, sb, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    o = 0;
    case (sub)
      0: begin t = sa + sb; r = t[31:0]; o = (t != longint'($signed(r))); end
      5, 7: begin t = sa - sb; r = t[31:0]; o = (t != longint'($signed(r))); end
      1: r = a | b;
      4: r = a & b;
      6: r = a ^ b;
      default: r = '0;
    endcase
    s = r[31];
    z = (r == 32'h0);
  endfunction

  function automatic string flag_tag(input int sub);
    if (sub == 7) return "R7 flags";
    if (sub == 0 || sub == 5) return "R8 flags";
    return "R9 flags";
  endfunction

  logic [31:0] pa [7] = '{32'h1, 32'h7fffffff, 32'h80000000, 32'h0d0c0b0a,
                          32'hd0c0b0a0, 32'hff, 32'h0d0c0b07};
  logic [31:0] pb [7] = '{32'h0d0c0b0a, 32'h1, 32'h1, 32'h0d0c0b0a,
                          32'h0d0c0b0a, 32'h0d0c0b0a, 32'h0d0c0b0a};

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  pkt [6];
    logic [31:0] r, tgt;
    bit s, z, o, bad;
    int sub;
    logic [7:0] shorts [5] = '{8'h2d, 8'h25, 8'h0d, 8'h35, 8'h3d};
    int short_sub [5] = '{5, 4, 1, 6, 7};
    logic [7:0] illegal [5] = '{8'h05, 8'h00, 8'hff, 8'h80, 8'hc7};

    for (int i = 0; i < 8; i++) rf[i] = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(byte_ready && !done && !err && !rf_we && !mem_rd && !mem_wr, "R1 idle",
        {27'b0, byte_ready, done, err, mem_rd, mem_wr}, 32'h10);
    chk({sf, zf, of_f} == 3'b000, "R1 flags", {29'b0, sf, zf, of_f}, 32'h0);
    rst_n = 1'b1;

    // R2 little-endian immediate, worked examples, R11 timing
    preload(3, 32'h1, 0, 0, 0);
    pkt = '{8'h81, 8'hc3, 8'h0a, 8'h0b, 8'h0c, 8'h0d};
    run_instr(pkt, 6);
    chk(rf[3] == 32'h0d0c0b0b, "R2 add example", rf[3], 32'h0d0c0b0b);
    chk(ready_busy, "R11 not ready while busy", {31'b0, ready_busy}, 32'h1);
    chk(got_done && !done_after, "R11 done single cycle", {30'b0, got_done, done_after}, 32'h2);
    chk(byte_ready, "R11 ready after done", {31'b0, byte_ready}, 32'h1);
    preload(3, 32'hd0c0b0a0, 0, 0, 0);
    pkt = '{8'h81, 8'hcb, 8'h0a, 8'h0b, 8'h0c, 8'h0d};
    run_instr(pkt, 6);
    chk(rf[3] == 32'hddccbbaa, "R2 or example", rf[3], 32'hddccbbaa);
    preload(3, 32'h2000 >> 7, 1, 0, 32'hff);
    pkt = '{8'h81, 8'h23, 8'h0a, 8'h0b, 8'h0c, 8'h0d};
    run_instr(pkt, 6);
    chk(mem[0] == 32'h0000000a, "R2 and example in memory", mem[0], 32'h0000000a);

    // grouped opcode sweep: all modes, sub-fields and r/m values
    for (int p = 0; p < 7; p++)
      for (int md = 0; md < 4; md++)
        for (int sb = 0; sb < 8; sb++)
          for (int rm = 0; rm < 8; rm++) begin
            if (md == 3) preload(rm, pa[p], 0, 0, 0);
            else preload(rm, 32'h100 + rm * 4, 1, rm, pa[p]);
            pkt = '{8'h81, {2'(md), 3'(sb), 3'(rm)}, pb[p][7:0], pb[p][15:8],
                    pb[p][23:16], pb[p][31:24]};
            run_instr(pkt, 6);
            bad = (sb == 2 || sb == 3 || md == 1 || md == 2 || (md == 0 && (rm == 4 || rm == 5)));
            tgt = (md == 3) ? rf[rm] : mem[rm];
            if (bad) begin
              chk(got_err && !got_done, "R10 rejected encoding", {30'b0, got_err, got_done}, 32'h2);
              chk({sf, zf, of_f} == {m_sf, m_zf, m_of}, "R10 flags kept",
                  {29'b0, sf, zf, of_f}, {29'b0, m_sf, m_zf, m_of});
              chk(tgt == pa[p], "R10 nothing written", tgt, pa[p]);
            end else begin
              model(sb, pa[p], pb[p], r, s, z, o);
              chk(got_done && !got_err, "R3 executes", {30'b0, got_done, got_err}, 32'h2);
              chk({sf, zf, of_f} == {s, z, o}, flag_tag(sb), {29'b0, sf, zf, of_f}, {29'b0, s, z, o});
              m_sf = s; m_zf = z; m_of = o;
              if (sb == 7) chk(tgt == pa[p], "R7 compare writes nothing", tgt, pa[p]);
              else if (md == 3) chk(tgt == r, "R4 register result", tgt, r);
              else begin
                chk(tgt == r, "R5 memory result", tgt, r);
                chk(rf[rm] == 32'h100 + rm * 4, "R5 address register kept", rf[rm], 32'h100 + rm * 4);
              end
            end
          end

    // short accumulator forms
    for (int k = 0; k < 5; k++)
      for (int p = 0; p < 7; p++) begin
        preload(0, pa[p], 0, 0, 0);
        pkt = '{shorts[k], pb[p][7:0], pb[p][15:8], pb[p][23:16], pb[p][31:24], 8'h00};
        run_instr(pkt, 5);
        sub = short_sub[k];
        model(sub, pa[p], pb[p], r, s, z, o);
        chk(got_done && !got_err, "R6 short form executes", {30'b0, got_done, got_err}, 32'h2);
        chk(rf[0] == ((sub == 7) ? pa[p] : r), "R6 accumulator result", rf[0], (sub == 7) ? pa[p] : r);
        chk({sf, zf, of_f} == {s, z, o}, flag_tag(sub), {29'b0, sf, zf, of_f}, {29'b0, s, z, o});
        m_sf = s; m_zf = z; m_of = o;
      end

    // unknown opcodes
    for (int k = 0; k < 5; k++) begin
      preload(0, 32'h1234, 0, 0, 0);
      pkt = '{illegal[k], 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
      run_instr(pkt, 1);
      chk(got_err && ready_busy, "R10 unknown opcode error next cycle", {30'b0, got_err, ready_busy}, 32'h3);
      chk({sf, zf, of_f} == {m_sf, m_zf, m_of} && rf[0] == 32'h1234, "R10 unknown opcode no effect",
          rf[0], 32'h1234);
      chk(byte_ready, "R10 idle after error", {31'b0, byte_ready}, 32'h1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule